// File: doc/BRIEF.md
# Four-Queue Read Selector with Pipelined Switch

This block is the read half of a four-queue word store. All of its logic runs on one free-running clock. A small write port fills four independent circular buffers. The read side pops words onto a 36-bit registered output bus from whichever queue is currently active. A new active queue is chosen by presenting a 6-bit read address together with an address-enable strobe. The address carries a 2-bit queue index, a null-queue bit and a 3-bit device identifier. The identifier must equal the block's own `DEV_ID` parameter before the selection counts.

A queue change is pipelined over three edges. On the edge that accepts the selection, a normal read (if `rd_en` is high) still draws from the old queue. The next edge pushes one more word from the old queue out, whether `rd_en` is high or low. The edge after that presents the first word of the new queue, also without `rd_en`. Normal `rd_en`-driven reads then continue from the new queue.

A forced word is skipped when its queue is empty. Selecting the null queue freezes all reads. Selections are refused until `prog_done` is high. Selections are also refused while a switch is still in its two forced phases.

Top module: `mq_read_sel`

## Requirements
- R1: `rd_addr[1:0]` is the queue index, `rd_addr[2]` the null-queue bit and `rd_addr[5:3]` a device ID. A selection is accepted on a rising edge only when `addr_en` is high, `flag_strobe` is low, `prog_done` is high and the ID equals `DEV_ID`. Otherwise the active queue is unchanged.
- R2: Outside a switch, an edge with `rd_en` high and a non-empty active queue pops that queue's oldest word onto `dout` and sets `dout_valid` for one cycle. With `rd_en` low, no word is popped and `dout` holds.
- R3: On the edge that accepts a selection, a read enabled by `rd_en` takes its word from the previously active queue.
- R4: On the first edge after acceptance, one word from the previously active queue is placed on `dout` regardless of `rd_en`.
- R5: On the second edge after acceptance, the oldest word of the newly selected queue is placed on `dout` regardless of `rd_en`. Later `rd_en` reads come from that queue.
- R6: A forced word (R4, R5) whose queue is empty is not produced: `dout_valid` stays low and `dout` holds.
- R7: While the null queue is active (also after reset), no queue is popped, `dout_valid` stays low and `dout` holds its last value.
- R8: With `prog_done` low, no selection is accepted.
- R9: `flag_strobe` never selects a queue. `addr_en` and `flag_strobe` are never high in the same cycle.
- R10: An `addr_en` pulse during the two forced edges of a switch is ignored.
- R11: Each queue keeps its own FIFO order and count. No word is lost or duplicated across switches. A write to a full queue (`DEPTH` words) is dropped. `q_empty[i]` is high exactly when queue i holds no word. Reset leaves `dout` at 0, `dout_valid` low and all queues empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_q | input | 2 | Queue written |
| wr_data | input | 36 | Word written |
| rd_addr | input | 6 | {device ID, null bit, queue index} |
| addr_en | input | 1 | Queue-select strobe |
| flag_strobe | input | 1 | Flag-side strobe; never selects a queue |
| rd_en | input | 1 | Read enable |
| prog_done | input | 1 | Configuration complete |
| dout | output | 36 | Registered output word |
| dout_valid | output | 1 | A word was placed on `dout` at the last edge |
| q_empty | output | 4 | Per-queue empty flags |

## Verification
The assertions assume that `addr_en` and `flag_strobe` are never high together. They also assume that `wr_q` stays within the four queues. The stimulus drives every strobe for one cycle at a time and raises `flag_strobe` only on its own with `addr_en` low. Each word written carries its queue index in bits 35:34. This lets a reference model of the four queues check, for every word that appears on `dout`, both its origin and its order.

// File: rtl/mq_pkg.sv
package mq_pkg;
  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_DRAIN = 2'd1,
    SW_LOAD  = 2'd2
  } sw_phase_e;
endpackage

// File: rtl/mq_queue_store.sv
module mq_queue_store #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 8,
  parameter int QIDX_W = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [QIDX_W-1:0]                     wr_q,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic                                  pop,
  input  logic [QIDX_W-1:0]                     pop_q,
  output logic [(1<<QIDX_W)-1:0][DATA_W-1:0]    head,
  output logic [(1<<QIDX_W)-1:0]                empty
);
  localparam int NUM_Q = 1 << QIDX_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  for (genvar qi = 0; qi < NUM_Q; qi++) begin : g_q
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr, wptr_n, rptr_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              push_ok, pop_ok;

    always_comb begin
      push_ok = wr_en && (wr_q == QIDX_W'(qi)) && (cnt != CNT_W'(DEPTH));
      pop_ok  = pop && (pop_q == QIDX_W'(qi)) && (cnt != '0);
      wptr_n  = wptr;
      rptr_n  = rptr;
      cnt_n   = cnt;
      if (push_ok) wptr_n = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr_n = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push_ok && !pop_ok) cnt_n = cnt + 1'b1;
      else if (pop_ok && !push_ok) cnt_n = cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wptr <= '0;
        rptr <= '0;
        cnt  <= '0;
      end else begin
        wptr <= wptr_n;
        rptr <= rptr_n;
        cnt  <= cnt_n;
      end
    end

    always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= wr_data;
    end

    assign head[qi]  = mem[rptr];
    assign empty[qi] = (cnt == '0);
  end
endmodule

// File: rtl/mq_sel_ctrl.sv
module mq_sel_ctrl
  import mq_pkg::*;
#(
  parameter int QIDX_W = 2,
  parameter int ID_W   = 3,
  parameter logic [ID_W-1:0] DEV_ID = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [QIDX_W+ID_W:0]       rd_addr,
  input  logic                       addr_en,
  input  logic                       flag_strobe,
  input  logic                       rd_en,
  input  logic                       prog_done,
  output logic [QIDX_W-1:0]          act_q,
  output logic                       act_null,
  output sw_phase_e                  sw_phase,
  output logic                       pop_req,
  output logic [QIDX_W-1:0]          pop_q
);
  localparam int ADDR_W = QIDX_W + 1 + ID_W;
  localparam int NULL_B = QIDX_W;

  logic [QIDX_W-1:0] old_q, act_q_n, old_q_n;
  logic              old_null, act_null_n, old_null_n;
  sw_phase_e         phase_n;
  logic              sel_hit;

  always_comb begin
    sel_hit    = addr_en && !flag_strobe && prog_done &&
                 (rd_addr[ADDR_W-1 -: ID_W] == DEV_ID);
    act_q_n    = act_q;
    act_null_n = act_null;
    old_q_n    = old_q;
    old_null_n = old_null;
    phase_n    = sw_phase;
    pop_req    = 1'b0;
    pop_q      = act_q;
    case (sw_phase)
      SW_IDLE: begin
        pop_req = rd_en && !act_null;
        if (sel_hit) begin
          old_q_n    = act_q;
          old_null_n = act_null;
          act_q_n    = rd_addr[QIDX_W-1:0];
          act_null_n = rd_addr[NULL_B];
          phase_n    = SW_DRAIN;
        end
      end
      SW_DRAIN: begin
        pop_req = !old_null;
        pop_q   = old_q;
        phase_n = SW_LOAD;
      end
      SW_LOAD: begin
        pop_req = !act_null;
        phase_n = SW_IDLE;
      end
      default: phase_n = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= '0;
      act_null <= 1'b1;
      old_q    <= '0;
      old_null <= 1'b1;
      sw_phase <= SW_IDLE;
    end else begin
      act_q    <= act_q_n;
      act_null <= act_null_n;
      old_q    <= old_q_n;
      old_null <= old_null_n;
      sw_phase <= phase_n;
    end
  end
endmodule

// File: rtl/mq_read_sel.sv
module mq_read_sel
  import mq_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 8,
  parameter int QIDX_W = 2,
  parameter int ID_W   = 3,
  parameter logic [ID_W-1:0] DEV_ID = 3'd5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [QIDX_W-1:0]         wr_q,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [QIDX_W+ID_W:0]      rd_addr,
  input  logic                      addr_en,
  input  logic                      flag_strobe,
  input  logic                      rd_en,
  input  logic                      prog_done,
  output logic [DATA_W-1:0]         dout,
  output logic                      dout_valid,
  output logic [(1<<QIDX_W)-1:0]    q_empty
);
  localparam int NUM_Q = 1 << QIDX_W;

  logic [NUM_Q-1:0][DATA_W-1:0] head;
  logic [QIDX_W-1:0]            act_q, pop_q;
  logic                         act_null, pop_req, pop_fire;
  sw_phase_e                    sw_phase;
  logic [DATA_W-1:0]            dout_n;

  mq_sel_ctrl #(.QIDX_W(QIDX_W), .ID_W(ID_W), .DEV_ID(DEV_ID)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .addr_en(addr_en),
    .flag_strobe(flag_strobe), .rd_en(rd_en), .prog_done(prog_done),
    .act_q(act_q), .act_null(act_null), .sw_phase(sw_phase),
    .pop_req(pop_req), .pop_q(pop_q)
  );

  mq_queue_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .QIDX_W(QIDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
    .pop(pop_fire), .pop_q(pop_q), .head(head), .empty(q_empty)
  );

  always_comb begin
    pop_fire = pop_req && !q_empty[pop_q];
    dout_n   = pop_fire ? head[pop_q] : dout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout       <= dout_n;
      dout_valid <= pop_fire;
    end
  end
endmodule

// File: rtl/mq_read_sel_chk.sv
module mq_read_sel_chk
  import mq_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int QIDX_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_en,
  input logic              flag_strobe,
  input logic              prog_done,
  input logic [DATA_W-1:0] dout,
  input logic              dout_valid,
  input logic [QIDX_W-1:0] act_q,
  input logic              act_null,
  input sw_phase_e         sw_phase
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(addr_en && flag_strobe)); // R9
  AST_LOCKED_SEL: assert property (@(posedge clk) disable iff (!rst_n) !prog_done |=> ($stable(act_q) && $stable(act_null))); // R8
  AST_DRAIN_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (sw_phase == SW_DRAIN) |=> (sw_phase == SW_LOAD)); // R4
  AST_LOAD_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (sw_phase == SW_LOAD) |=> (sw_phase == SW_IDLE)); // R5
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !dout_valid |-> $stable(dout)); // R6
  AST_NULL_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (act_null && sw_phase == SW_IDLE) |=> !dout_valid); // R7
endmodule

bind mq_read_sel mq_read_sel_chk #(.DATA_W(DATA_W), .QIDX_W(QIDX_W)) u_chk (.*);

// File: tb/mq_read_sel_tb.sv
`timescale 1ns/1ps
module mq_read_sel_tb;
  localparam int DEPTH = 8;
  localparam logic [2:0] MY_ID = 3'd5;

  logic        clk, rst_n, wr_en, addr_en, flag_strobe, rd_en, prog_done;
  logic [1:0]  wr_q;
  logic [35:0] wr_data, dout, prev_dout;
  logic [5:0]  rd_addr;
  logic        dout_valid;
  logic [3:0]  q_empty;

  int checks = 0, fails = 0;
  int seq [4] = '{0, 0, 0, 0};
  logic [35:0] mdl [4][$];

  mq_read_sel u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
    .rd_addr(rd_addr), .addr_en(addr_en), .flag_strobe(flag_strobe),
    .rd_en(rd_en), .prog_done(prog_done), .dout(dout),
    .dout_valid(dout_valid), .q_empty(q_empty)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one rising edge; sample at the following falling edge; score every word (R11)
  task automatic tick();
    prev_dout = dout;
    @(negedge clk);
    if (dout_valid) begin
      if (mdl[dout[35:34]].size() == 0) chk(1'b0, "R11 unexpected word", dout, '0);
      else begin
        logic [35:0] e;
        e = mdl[dout[35:34]].pop_front();
        chk(dout == e, "R11 order", dout, e);
      end
    end
  endtask

  task automatic expect_word(input logic [1:0] q, input string tag);
    chk(dout_valid && dout[35:34] == q, tag, {dout_valid, dout[35:34]}, {1'b1, q});
  endtask

  task automatic expect_none(input string tag);
    chk(!dout_valid && dout == prev_dout, tag, dout, prev_dout);
  endtask

  task automatic push(input logic [1:0] q, input int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_q = q; wr_data = {q, 2'b00, 32'(seq[q])};
      if (mdl[q].size() < DEPTH) mdl[q].push_back(wr_data);
      seq[q]++;
      tick();
    end
    wr_en = 1'b0;
  endtask

  function automatic logic [5:0] qaddr(input logic [2:0] id, input logic nul, input logic [1:0] q);
    return {id, nul, q};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 0; wr_q = 0; wr_data = 0; rd_addr = 0;
    addr_en = 0; flag_strobe = 0; rd_en = 0; prog_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk(dout == '0 && !dout_valid && q_empty == 4'hF, "R11 reset", {dout_valid, q_empty}, {1'b0, 4'hF});
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    expect_none("R7 null after reset");
  endtask

  task automatic t_locked();
    push(2'd0, 5);
    chk(q_empty == 4'hE, "R11 empty flags", q_empty, 4'hE);
    addr_en = 1'b1; rd_addr = qaddr(MY_ID, 1'b0, 2'd0); tick(); addr_en = 1'b0;
    expect_none("R8 select edge");
    rd_en = 1'b1;
    tick(); expect_none("R8 locked read a");
    tick(); expect_none("R8 locked read b");
    rd_en = 1'b0; prog_done = 1'b1;
  endtask

  task automatic t_mismatch_strobe();
    addr_en = 1'b1; rd_addr = qaddr(3'd2, 1'b0, 2'd0); tick(); addr_en = 1'b0;
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    expect_none("R1 id mismatch");
    flag_strobe = 1'b1; rd_addr = qaddr(MY_ID, 1'b0, 2'd0); tick(); flag_strobe = 1'b0;
    rd_en = 1'b1; tick(); tick(); rd_en = 1'b0;
    expect_none("R9 strobe no select");
  endtask

  task automatic t_switch_new();
    addr_en = 1'b1; rd_addr = qaddr(MY_ID, 1'b0, 2'd0); tick(); addr_en = 1'b0;
    expect_none("R3 accept from null");
    tick(); expect_none("R4 old is null");
    tick(); expect_word(2'd0, "R5 new first word");
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    expect_word(2'd0, "R2 read");
    tick(); expect_none("R2 no rd_en");
  endtask

  task automatic t_switch_old();
    push(2'd1, 3);
    addr_en = 1'b1; rd_en = 1'b1; rd_addr = qaddr(MY_ID, 1'b0, 2'd1); tick();
    addr_en = 1'b0; rd_en = 1'b0;
    expect_word(2'd0, "R3 accept edge old read");
    tick(); expect_word(2'd0, "R4 forced old");
    tick(); expect_word(2'd1, "R5 forced new");
  endtask

  task automatic t_empty_busy();
    addr_en = 1'b1; rd_addr = qaddr(MY_ID, 1'b0, 2'd2); tick();
    rd_addr = qaddr(MY_ID, 1'b0, 2'd3);
    expect_none("R3 no rd_en at accept");
    tick(); addr_en = 1'b0;
    expect_word(2'd1, "R4 forced old q1");
    tick(); expect_none("R6 new queue empty");
    push(2'd3, 1);
    push(2'd2, 1);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    expect_word(2'd2, "R10 select ignored mid-switch");
  endtask

  task automatic t_null();
    addr_en = 1'b1; rd_addr = qaddr(MY_ID, 1'b1, 2'd3); tick(); addr_en = 1'b0;
    expect_none("R7 accept null");
    tick(); expect_none("R6 old q2 empty");
    tick(); expect_none("R7 no forced new");
    rd_en = 1'b1;
    tick(); expect_none("R7 null read a");
    tick(); expect_none("R7 null read b");
    rd_en = 1'b0;
  endtask

  task automatic drain(input logic [1:0] q, output int got);
    got = 0;
    addr_en = 1'b1; rd_addr = qaddr(MY_ID, 1'b0, q); tick(); addr_en = 1'b0;
    tick(); tick();
    if (dout_valid && dout[35:34] == q) got++;
    rd_en = 1'b1;
    for (int i = 0; i < DEPTH + 2; i++) begin
      tick();
      if (dout_valid && dout[35:34] == q) got++;
    end
    rd_en = 1'b0;
  endtask

  task automatic t_full();
    int got;
    push(2'd3, DEPTH + 2);
    chk(!q_empty[3], "R11 q3 not empty", q_empty, 4'h7);
    drain(2'd3, got);
    chk(got == DEPTH, "R11 full drops", 36'(got), 36'(DEPTH));
    chk(q_empty[3], "R11 q3 empty after drain", q_empty, 4'h8);
  endtask

  task automatic t_final();
    int got;
    drain(2'd0, got);
    drain(2'd1, got);
    drain(2'd2, got);
    chk(q_empty == 4'hF, "R11 all empty", q_empty, 4'hF);
    for (int q = 0; q < 4; q++)
      chk(mdl[q].size() == 0, "R11 no lost word", 36'(mdl[q].size()), '0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_locked();
    t_mismatch_strobe();
    t_switch_new();
    t_switch_old();
    t_empty_busy();
    t_null();
    t_full();
    t_final();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule